// File: doc/BRIEF.md
# Lookahead Dimension-Ordered Route Unit

This block sits on one input port of a five-port router in a two-dimensional mesh or torus. Routing runs one hop ahead. A head flit arrives with the output port it must use at this router already written into it. The unit passes that port straight to the switch. In the same cycle it works out where the flit will land next, and which port the packet will need at that next router to keep moving toward its destination. It goes along X until the X coordinates match, then along Y. It writes that port back into the head flit before the flit leaves, so the downstream router never has to compute its own route.

Body and tail flits carry no routing data. They pass through untouched and are steered to the port latched from their packet's head. The local node's coordinates come in as inputs. A parameter selects mesh or torus. In torus mode the next node's coordinates wrap around, and the direction along each ring is the shorter way round. The whole path is one register stage.

Top module: `lookaheadRoute`

## Requirements
- R1: While reset is held and at the first sample after it, outValid, portErr, curPort and outFlit are all zero.
- R2: outValid is high exactly one clock edge after each cycle in which inValid is high, and low otherwise.
- R3: Flit type sits in bits [31:30] (00 body, 01 tail, 10 head, 11 single-flit head and tail); a type with bit 31 set is a head. For a head flit, curPort equals the route field in bits [29:27], where 0 Local, 1 North (Y+1), 2 East (X+1), 3 South (Y-1), 4 West (X-1).
- R4: For a head whose route field is 1 to 4, the output flit equals the input flit, except that bits [29:27] hold the port needed at the next node. The next node is the local node moved one step in the field's direction. The destination X is in bits [26:24] and the destination Y in bits [23:21]. The port is chosen X first (East if the destination X is larger, West if smaller), then Y (North if larger, South if smaller).
- R5: When the next node equals the destination, the rewritten route field is Local (0).
- R6: In torus mode, a step past the last column or row wraps to coordinate 0, and a step below 0 wraps to the last one.
- R7: In torus mode, the direction along each dimension is the one with the shorter hop count around the ring. When both ways are equally long, which only happens on an even-sized ring, the positive direction (East or North) is taken.
- R8: Body and tail flits leave unchanged. Their curPort is the route field of the most recent head flit, and portErr is low for them.
- R9: A head whose route field is 5, 6 or 7 raises portErr with its output. Its flit leaves unchanged and curPort shows the raw field.
- R10: A head whose route field is Local leaves unchanged, with curPort Local.
- R11: A head leaving North or South never carries an East or West lookahead port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Flit on inFlit is valid this cycle |
| inFlit | input | FLIT_W | Incoming flit |
| myX | input | CW | X coordinate of this router |
| myY | input | CW | Y coordinate of this router |
| outValid | output | 1 | outFlit and curPort are valid |
| outFlit | output | FLIT_W | Flit with rewritten lookahead field |
| curPort | output | 3 | Output port to use at this router |
| portErr | output | 1 | Head flit carried an undefined port code |

## Verification
Two functions can land in the same cycle. One is handing out the latched route for a packet's last flit. The other is capturing a new route from the head that follows it back to back. The bench provokes this with tail and head flits on consecutive cycles, including single-flit packets and heads with bad codes. It judges the tail by the old packet's route and the head by its own field. A second pairing is a torus step that wraps and also lands on the destination or on a tie distance. Directed cases at the ring edges cover it, and their expected ports come from the bench's own routing functions.

// File: rtl/lrPkg.sv
package lrPkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_EAST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } portE;

  // strobes from flit decode to datapath
  typedef struct packed {
    logic take;
    logic isHead;
    logic badPort;
    logic ejecting;
  } ctrlS;
endpackage

// File: rtl/lrCtrl.sv
module lrCtrl
  import lrPkg::*;
(
  input  logic       inValid,
  input  logic [1:0] flitType,
  input  logic [2:0] routeField,
  output ctrlS       strobes
);
  logic headSeen;
  logic codeBad;

  assign headSeen = flitType[1];
  assign codeBad  = (routeField > 3'd4);

  always_comb begin
    strobes          = '0;
    strobes.take     = inValid;
    strobes.isHead   = inValid && headSeen;
    strobes.badPort  = inValid && headSeen && codeBad;
    strobes.ejecting = inValid && headSeen && (routeField == PORT_LOCAL);
  end
endmodule

// File: rtl/lrDatapath.sv
module lrDatapath
  import lrPkg::*;
#(
  parameter int NX     = 5,
  parameter int NY     = 5,
  parameter int CW     = 3,
  parameter int FLIT_W = 32,
  parameter bit TORUS  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlS              strobes,
  input  logic [FLIT_W-1:0] inFlit,
  input  logic [CW-1:0]     myX,
  input  logic [CW-1:0]     myY,
  output logic              outValid,
  output logic [FLIT_W-1:0] outFlit,
  output logic [2:0]        curPort,
  output logic              portErr
);
  localparam int ROUTE_LO = FLIT_W - 5;
  localparam int DX_LO    = ROUTE_LO - CW;
  localparam int DY_LO    = DX_LO - CW;
  localparam int CW1      = CW + 1;
  localparam logic [CW-1:0] XMAX = CW'(NX - 1);
  localparam logic [CW-1:0] YMAX = CW'(NY - 1);
  localparam logic [CW:0]   NXV  = CW1'(NX);
  localparam logic [CW:0]   NYV  = CW1'(NY);

  logic [2:0]        routeField;
  logic [CW-1:0]     destX, destY;
  logic [CW-1:0]     nextX, nextY;
  logic              goEast, goNorth;
  logic [2:0]        laPort;
  logic [FLIT_W-1:0] newFlit;
  logic [2:0]        heldRoute;

  assign routeField = inFlit[ROUTE_LO +: 3];
  assign destX      = inFlit[DX_LO +: CW];
  assign destY      = inFlit[DY_LO +: CW];

  generate
    if (TORUS) begin : g_torus
      logic [CW:0] fwdX, fwdY;
      always_comb begin
        nextX = myX;
        nextY = myY;
        case (routeField)
          PORT_EAST:  nextX = (myX == XMAX) ? '0 : myX + 1'b1;
          PORT_WEST:  nextX = (myX == '0) ? XMAX : myX - 1'b1;
          PORT_NORTH: nextY = (myY == YMAX) ? '0 : myY + 1'b1;
          PORT_SOUTH: nextY = (myY == '0) ? YMAX : myY - 1'b1;
          default: ;
        endcase
        fwdX = (destX >= nextX) ? ({1'b0, destX} - {1'b0, nextX})
                                : ({1'b0, destX} + NXV - {1'b0, nextX});
        fwdY = (destY >= nextY) ? ({1'b0, destY} - {1'b0, nextY})
                                : ({1'b0, destY} + NYV - {1'b0, nextY});
        goEast  = ({fwdX[CW-1:0], 1'b0} <= NXV);
        goNorth = ({fwdY[CW-1:0], 1'b0} <= NYV);
      end
    end else begin : g_mesh
      always_comb begin
        nextX = myX;
        nextY = myY;
        case (routeField)
          PORT_EAST:  nextX = myX + 1'b1;
          PORT_WEST:  nextX = myX - 1'b1;
          PORT_NORTH: nextY = myY + 1'b1;
          PORT_SOUTH: nextY = myY - 1'b1;
          default: ;
        endcase
        goEast  = (destX > nextX);
        goNorth = (destY > nextY);
      end
    end
  endgenerate

  always_comb begin
    if (nextX != destX)      laPort = goEast ? PORT_EAST : PORT_WEST;
    else if (nextY != destY) laPort = goNorth ? PORT_NORTH : PORT_SOUTH;
    else                     laPort = PORT_LOCAL;
    newFlit = inFlit;
    newFlit[ROUTE_LO +: 3] = laPort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outFlit   <= '0;
      curPort   <= '0;
      portErr   <= 1'b0;
      heldRoute <= '0;
    end else begin
      outValid <= strobes.take;
      if (strobes.isHead) begin
        heldRoute <= routeField;
        curPort   <= routeField;
        portErr   <= strobes.badPort;
        outFlit   <= (strobes.badPort || strobes.ejecting) ? inFlit : newFlit;
      end else if (strobes.take) begin
        curPort <= heldRoute;
        portErr <= 1'b0;
        outFlit <= inFlit;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> outValid);

  // R3
  head_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.isHead |=> curPort == $past(inFlit[ROUTE_LO +: 3]));

  // R8
  body_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && !strobes.isHead) |=> (outFlit == $past(inFlit)) && !portErr);

  // R9
  bad_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && portErr) |-> (curPort > 3'd4) && (outFlit == $past(inFlit)));

  // R11
  no_turn_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFlit[FLIT_W-1] && !portErr &&
     (curPort == PORT_NORTH || curPort == PORT_SOUTH))
    |-> (outFlit[ROUTE_LO +: 3] != PORT_EAST && outFlit[ROUTE_LO +: 3] != PORT_WEST));
endmodule

// File: rtl/lookaheadRoute.sv
module lookaheadRoute
  import lrPkg::*;
#(
  parameter int NX     = 5,
  parameter int NY     = 5,
  parameter int CW     = 3,
  parameter int FLIT_W = 32,
  parameter bit TORUS  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FLIT_W-1:0] inFlit,
  input  logic [CW-1:0]     myX,
  input  logic [CW-1:0]     myY,
  output logic              outValid,
  output logic [FLIT_W-1:0] outFlit,
  output logic [2:0]        curPort,
  output logic              portErr
);
  ctrlS strobes;

  lrCtrl u_ctrl (
    .inValid    (inValid),
    .flitType   (inFlit[FLIT_W-1 -: 2]),
    .routeField (inFlit[FLIT_W-3 -: 3]),
    .strobes    (strobes)
  );

  lrDatapath #(
    .NX(NX), .NY(NY), .CW(CW), .FLIT_W(FLIT_W), .TORUS(TORUS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inFlit   (inFlit),
    .myX      (myX),
    .myY      (myY),
    .outValid (outValid),
    .outFlit  (outFlit),
    .curPort  (curPort),
    .portErr  (portErr)
  );
endmodule

// File: tb/lookaheadRoute_bench.sv
module lookaheadRoute_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        mV, tV;
  logic [31:0] mF, tF;
  logic [2:0]  mX, mY, tX, tY;
  logic        mOV, tOV, mErr, tErr;
  logic [31:0] mOF, tOF;
  logic [2:0]  mP, tP;

  lookaheadRoute #(.NX(5), .NY(5), .TORUS(1'b0)) u_lookaheadRoute (
    .clk(clk), .rstN(rstN), .inValid(mV), .inFlit(mF), .myX(mX), .myY(mY),
    .outValid(mOV), .outFlit(mOF), .curPort(mP), .portErr(mErr));

  lookaheadRoute #(.NX(4), .NY(5), .TORUS(1'b1)) u_lookaheadRouteTorus (
    .clk(clk), .rstN(rstN), .inValid(tV), .inFlit(tF), .myX(tX), .myY(tY),
    .outValid(tOV), .outFlit(tOF), .curPort(tP), .portErr(tErr));

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [2:0] heldM = 3'd0, heldT = 3'd0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] route(input int cx, cy, dx, dy, input bit tor, input int nx, ny);
    int pos;
    if (cx != dx) begin
      if (tor) begin pos = (dx - cx + nx) % nx; return (2*pos <= nx) ? 3'd2 : 3'd4; end
      return (dx > cx) ? 3'd2 : 3'd4;
    end
    if (cy != dy) begin
      if (tor) begin pos = (dy - cy + ny) % ny; return (2*pos <= ny) ? 3'd1 : 3'd3; end
      return (dy > cy) ? 3'd1 : 3'd3;
    end
    return 3'd0;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] ty, input logic [2:0] rf, input int dx, dy);
    logic [31:0] f;
    f = $urandom;
    f[31:30] = ty; f[29:27] = rf; f[26:24] = 3'(dx); f[23:21] = 3'(dy);
    return f;
  endfunction

  function automatic logic [31:0] expFlit(input logic [31:0] f, input int x, y, input bit tor, input int nx, ny);
    int ax, ay;
    logic [31:0] r;
    r = f;
    if (!f[31] || f[29:27] == 3'd0 || f[29:27] > 3'd4) return r;
    ax = x; ay = y;
    case (f[29:27])
      3'd1: ay = tor ? (y + 1) % ny : y + 1;
      3'd3: ay = tor ? (y + ny - 1) % ny : y - 1;
      3'd2: ax = tor ? (x + 1) % nx : x + 1;
      default: ax = tor ? (x + nx - 1) % nx : x - 1;
    endcase
    r[29:27] = route(ax, ay, int'(f[26:24]), int'(f[23:21]), tor, nx, ny);
    return r;
  endfunction

  function automatic string flitTag(input logic [31:0] f, input logic [31:0] e, input bit tor);
    if (!f[31]) return "R8";
    if (f[29:27] > 3'd4) return "R9";
    if (f[29:27] == 3'd0) return "R10";
    if (e[29:27] == 3'd0) return "R5";
    if (tor) return "R7";
    return "R4";
  endfunction

  // one cycle on both units; expectations fixed before the edge, compared after it
  task automatic cyc(input logic mv, input logic [31:0] mf, input int mx, my,
                     input logic tv, input logic [31:0] tf, input int tx, ty,
                     input string extra);
    logic [31:0] emF, etF;
    logic [2:0] emP, etP;
    mV = mv; mF = mf; mX = 3'(mx); mY = 3'(my);
    tV = tv; tF = tf; tX = 3'(tx); tY = 3'(ty);
    emF = expFlit(mf, mx, my, 1'b0, 5, 5);
    etF = expFlit(tf, tx, ty, 1'b1, 4, 5);
    if (mv && mf[31]) heldM = mf[29:27];
    if (tv && tf[31]) heldT = tf[29:27];
    emP = heldM; etP = heldT;
    @(posedge clk);
    @(negedge clk);
    check(mOV == mv, "R2", 32'(mOV), 32'(mv));
    check(tOV == tv, "R2", 32'(tOV), 32'(tv));
    if (mv) begin
      check(mP == emP, mf[31] ? "R3" : "R8", 32'(mP), 32'(emP));
      check(mErr == (mf[31] && mf[29:27] > 3'd4), "R9", 32'(mErr), 32'(mf[31] && mf[29:27] > 3'd4));
      check(mOF == emF, (extra != "") ? extra : flitTag(mf, emF, 1'b0), mOF, emF);
    end
    if (tv) begin
      check(tP == etP, tf[31] ? "R3" : "R8", 32'(tP), 32'(etP));
      check(tErr == (tf[31] && tf[29:27] > 3'd4), "R9", 32'(tErr), 32'(tf[31] && tf[29:27] > 3'd4));
      check(tOF == etF, (extra != "") ? extra : flitTag(tf, etF, 1'b1), tOF, etF);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] f;
    int x, y, dx, dy;
    void'($urandom(32'd20240607));
    mV = 0; tV = 0; mF = 0; tF = 0; mX = 0; mY = 0; tX = 0; tY = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mOV == 0 && mErr == 0 && mP == 0 && mOF == 0, "R1", mOF, 32'd0);
    check(tOV == 0 && tErr == 0 && tP == 0 && tOF == 0, "R1", tOF, 32'd0);
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "");
    check(mOF == 0 && tOF == 0 && mP == 0, "R1", mOF | tOF, 32'd0);

    // R4: mesh step east lands on X match, then heads north
    cyc(1, mk(2'b10, 3'd2, 1, 3), 0, 0, 0, 0, 0, 0, "R4");
    // R5: next node equals destination
    cyc(1, mk(2'b11, 3'd2, 2, 3), 1, 3, 0, 0, 0, 0, "R5");
    // R8: body and tail follow latched route, back to back with new head
    cyc(1, mk(2'b00, 3'd6, 0, 0), 3, 3, 0, 0, 0, 0, "R8");
    cyc(1, mk(2'b10, 3'd1, 1, 4), 1, 2, 0, 0, 0, 0, "R11");
    cyc(1, mk(2'b01, 3'd3, 4, 4), 1, 2, 0, 0, 0, 0, "R8");
    // R9: undefined code; R10: local ejection
    cyc(1, mk(2'b10, 3'd6, 2, 2), 2, 2, 0, 0, 0, 0, "R9");
    cyc(1, mk(2'b00, 3'd0, 2, 2), 2, 2, 0, 0, 0, 0, "R8");
    cyc(1, mk(2'b11, 3'd0, 2, 2), 2, 2, 0, 0, 0, 0, "R10");
    // R6: torus wraps east x=3 -> 0, dest x=1 -> East
    cyc(0, 0, 0, 0, 1, mk(2'b10, 3'd2, 1, 0), 3, 0, "R6");
    // R6: west wrap 0 -> 3, dest x=2 shorter way is West
    cyc(0, 0, 0, 0, 1, mk(2'b10, 3'd4, 2, 0), 0, 0, "R6");
    // R7: tie on 4-ring: next x=0, dest x=2 -> East
    cyc(0, 0, 0, 0, 1, mk(2'b10, 3'd2, 2, 1), 3, 1, "R7");
    // R6: north wrap y=4 -> 0, dest y=0 -> Local
    cyc(0, 0, 0, 0, 1, mk(2'b10, 3'd1, 1, 0), 1, 4, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] g;
      logic mv, tv;
      int tx, ty;
      x = $urandom % 5; y = $urandom % 5; dx = $urandom % 5; dy = $urandom % 5;
      f = mk(2'($urandom), route(x, y, dx, dy, 1'b0, 5, 5), dx, dy);
      if ($urandom % 10 == 0) f[29:27] = 3'(5 + $urandom % 3);
      tx = $urandom % 4; ty = $urandom % 5; dx = $urandom % 4; dy = $urandom % 5;
      g = mk(2'($urandom), route(tx, ty, dx, dy, 1'b1, 4, 5), dx, dy);
      if ($urandom % 10 == 0) g[29:27] = 3'(5 + $urandom % 3);
      mv = ($urandom % 8) != 0;
      tv = ($urandom % 8) != 0;
      cyc(mv, f, x, y, tv, g, tx, ty, "");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule